// File: doc/BRIEF.md
# Instruction-Pair Dependency Checker

A static instruction scheduler asks one question of every pair of instructions: may the later one, B, be hoisted above the earlier one, A? This block answers it. It takes the opcode class and one marker bit of each instruction, its three register fields and its memory operand field, plus two condition bits supplied by the scheduler. It drives a single dependency bit that is high when B must stay below A.

Internally the block decodes each opcode into a kind. The kinds are jump source, jump destination, load, store, unary ALU op and binary ALU op. It compares the operand fields of the two instructions with its own equality comparators. It evaluates a fixed sum of products over those results and ORs every product into the output.

A parameter chooses between a combinational output and a registered output. With the registered output, the bit and its valid strobe appear one clock after the inputs are presented.

Top module: `dep_check_top`

## Requirements
- R1: `*_cls` encodes the class as follows: 2'b00 is a jump, 2'b01 is a load/store, 2'b10 is a unary ALU op and 2'b11 is a binary ALU op. `*_mark` selects store over load in the load/store class, and jump destination over jump source in the jump class.
- R2: dep is set when A is a load, B is not a jump and A.reg0 equals B.reg0. It is also set when A is a store, B is a load or an ALU op, and the two reg0 fields match.
- R3: dep is set when A is an ALU op, B is not a jump and the two reg0 fields match.
- R4: dep is set when B is an ALU op, A is a load or an ALU op, and A.reg0 equals B.reg1. It is also set under the same class conditions when B is binary and A.reg0 equals B.reg2. B.reg2 is ignored when B is unary.
- R5: dep is set when A is a store and a_mem equals b_mem, whatever B is. It is also set when A is a load, B is a store and the memory fields are equal.
- R6: dep is set when A is a store, B is a jump source and slot_mismatch is high.
- R7: dep is set when A is an ALU op, B is not a jump and A.reg1 equals B.reg0. It is also set when A is binary, B is not a jump and A.reg2 equals B.reg0. A.reg2 is ignored when A is unary.
- R8: dep is set whenever A or B is a jump destination.
- R9: dep is set when A is a jump source and min_target_hit is high.
- R10: dep is set when A is a jump source and B is either a store or a jump source.
- R11: dep is the OR of the products in R2 to R10. It is low when none of them holds.
- R12: With REG_OUT=1, reset clears out_valid and dep. out_valid follows in_valid one clock later. dep holds the result for the inputs presented in the previous cycle when in_valid was high, and otherwise keeps its value.
- R13: With REG_OUT=0, dep is the combinational result of the current inputs and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair is valid |
| a_cls | input | 2 | Class of earlier instruction A |
| a_mark | input | 1 | Store / jump-destination marker of A |
| a_reg0 | input | RW | First register field of A |
| a_reg1 | input | RW | Second register field of A |
| a_reg2 | input | RW | Third register field of A |
| a_mem | input | MW | Memory operand field of A |
| b_cls | input | 2 | Class of later instruction B |
| b_mark | input | 1 | Store / jump-destination marker of B |
| b_reg0 | input | RW | First register field of B |
| b_reg1 | input | RW | Second register field of B |
| b_reg2 | input | RW | Third register field of B |
| b_mem | input | MW | Memory operand field of B |
| slot_mismatch | input | 1 | Scheduler flag: current slot differs from the latency instruction |
| min_target_hit | input | 1 | Scheduler flag: minimum-destination condition |
| out_valid | output | 1 | Result valid |
| dep | output | 1 | B must not move above A |

## Verification
The bench builds two instances with default widths (RW=5, MW=8) and feeds both the same stimulus. u0 uses REG_OUT=1 and u1 uses REG_OUT=0. u1 exposes the products directly in the same cycle. u0 brings the one-cycle latency, the reset state and the hold-on-idle behaviour within reach. Every class and marker combination of A and B is swept with random operands drawn from a small value range, so that register and memory matches occur often. Directed cases then isolate each product and its ignored fields.

// File: rtl/dep_pkg.sv
package dep_pkg;

  localparam logic [1:0] CLS_JUMP  = 2'b00;
  localparam logic [1:0] CLS_LDST  = 2'b01;
  localparam logic [1:0] CLS_UNARY = 2'b10;
  localparam logic [1:0] CLS_BIN   = 2'b11;

  localparam int NTERM = 14;

  typedef struct packed {
    logic is_jsrc;
    logic is_jdest;
    logic is_load;
    logic is_store;
    logic is_alu;
    logic is_bin;
  } kind_t;

  typedef struct packed {
    logic mem;
    logic a2b0;
    logic a1b0;
    logic a0b2;
    logic a0b1;
    logic a0b0;
  } match_t;

endpackage

// File: rtl/dep_decode.sv
module dep_decode
  import dep_pkg::*;
(
  input  logic [1:0] cls,
  input  logic       mark,
  output kind_t      kind
);
  always_comb begin
    kind          = '0;
    kind.is_jsrc  = (cls == CLS_JUMP) && !mark;
    kind.is_jdest = (cls == CLS_JUMP) &&  mark;
    kind.is_load  = (cls == CLS_LDST) && !mark;
    kind.is_store = (cls == CLS_LDST) &&  mark;
    kind.is_alu   = cls[1];
    kind.is_bin   = (cls == CLS_BIN);
  end
endmodule

// File: rtl/dep_cmp.sv
module dep_cmp
  import dep_pkg::*;
#(
  parameter int RW = 5,
  parameter int MW = 8
) (
  input  logic [RW-1:0] a_reg0,
  input  logic [RW-1:0] a_reg1,
  input  logic [RW-1:0] a_reg2,
  input  logic [MW-1:0] a_mem,
  input  logic [RW-1:0] b_reg0,
  input  logic [RW-1:0] b_reg1,
  input  logic [RW-1:0] b_reg2,
  input  logic [MW-1:0] b_mem,
  output match_t        hit
);
  localparam int NPAIR = 5;

  logic [NPAIR-1:0][RW-1:0] lhs;
  logic [NPAIR-1:0][RW-1:0] rhs;
  logic [NPAIR-1:0]         eq;

  assign lhs = {a_reg2, a_reg1, a_reg0, a_reg0, a_reg0};
  assign rhs = {b_reg0, b_reg0, b_reg2, b_reg1, b_reg0};

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign eq[i] = (lhs[i] == rhs[i]);
  end

  assign hit.a0b0 = eq[0];
  assign hit.a0b1 = eq[1];
  assign hit.a0b2 = eq[2];
  assign hit.a1b0 = eq[3];
  assign hit.a2b0 = eq[4];
  assign hit.mem  = (a_mem == b_mem);
endmodule

// File: rtl/dep_terms.sv
module dep_terms
  import dep_pkg::*;
(
  input  kind_t  ka,
  input  kind_t  kb,
  input  match_t hit,
  input  logic   slot_mismatch,
  input  logic   min_target_hit,
  output logic   dep
);
  logic [NTERM-1:0] t;
  logic b_not_jump;
  logic b_jump;

  assign b_jump     = kb.is_jsrc | kb.is_jdest;
  assign b_not_jump = !b_jump;

  // R2: earlier load/store against first register
  assign t[0]  = ka.is_load  && b_not_jump && hit.a0b0;
  assign t[1]  = ka.is_store && (kb.is_load || kb.is_alu) && hit.a0b0;
  // R3: earlier ALU op writes first register
  assign t[2]  = ka.is_alu && b_not_jump && hit.a0b0;
  // R4: later ALU reads A's first register
  assign t[3]  = kb.is_alu && (ka.is_load || ka.is_alu) && hit.a0b1;
  assign t[4]  = kb.is_bin && (ka.is_load || ka.is_alu) && hit.a0b2;
  // R5: memory operand overlap
  assign t[5]  = ka.is_store && hit.mem;
  assign t[6]  = ka.is_load && kb.is_store && hit.mem;
  // R6: jump source behind a store
  assign t[7]  = ka.is_store && kb.is_jsrc && slot_mismatch;
  // R7: A's source registers against B's first register
  assign t[8]  = ka.is_alu && b_not_jump && hit.a1b0;
  assign t[9]  = ka.is_bin && b_not_jump && hit.a2b0;
  // R8: jump destinations are pinned
  assign t[10] = ka.is_jdest;
  assign t[11] = kb.is_jdest;
  // R9, R10: earlier jump source
  assign t[12] = ka.is_jsrc && min_target_hit;
  assign t[13] = ka.is_jsrc && (kb.is_store || kb.is_jsrc);

  // R11: single OR plane
  assign dep = |t;
endmodule

// File: rtl/dep_outreg.sv
module dep_outreg #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic dep_in,
  output logic out_valid,
  output logic dep_out
);
  if (REG_OUT) begin : g_reg
    logic vld_q;
    logic dep_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        dep_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) dep_q <= dep_in;
      end
    end

    assign out_valid = vld_q;
    assign dep_out   = dep_q;

    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_valid && dep_out == $past(dep_in)));
    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(dep_out)));
  end else begin : g_comb
    // R13: pass-through
    assign out_valid = in_valid;
    assign dep_out   = dep_in;
  end
endmodule

// File: rtl/dep_check_top.sv
module dep_check_top
  import dep_pkg::*;
#(
  parameter int RW      = 5,
  parameter int MW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    a_cls,
  input  logic          a_mark,
  input  logic [RW-1:0] a_reg0,
  input  logic [RW-1:0] a_reg1,
  input  logic [RW-1:0] a_reg2,
  input  logic [MW-1:0] a_mem,
  input  logic [1:0]    b_cls,
  input  logic          b_mark,
  input  logic [RW-1:0] b_reg0,
  input  logic [RW-1:0] b_reg1,
  input  logic [RW-1:0] b_reg2,
  input  logic [MW-1:0] b_mem,
  input  logic          slot_mismatch,
  input  logic          min_target_hit,
  output logic          out_valid,
  output logic          dep
);
  kind_t  ka, kb;
  match_t hit;
  logic   dep_comb;

  dep_decode u_dec_a (.cls(a_cls), .mark(a_mark), .kind(ka));
  dep_decode u_dec_b (.cls(b_cls), .mark(b_mark), .kind(kb));

  dep_cmp #(.RW(RW), .MW(MW)) u_cmp (
    .a_reg0(a_reg0), .a_reg1(a_reg1), .a_reg2(a_reg2), .a_mem(a_mem),
    .b_reg0(b_reg0), .b_reg1(b_reg1), .b_reg2(b_reg2), .b_mem(b_mem),
    .hit(hit)
  );

  dep_terms u_terms (
    .ka(ka), .kb(kb), .hit(hit),
    .slot_mismatch(slot_mismatch), .min_target_hit(min_target_hit),
    .dep(dep_comb)
  );

  dep_outreg #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dep_in(dep_comb),
    .out_valid(out_valid), .dep_out(dep)
  );

  p_jdest_pin_r8: assert property (@(posedge clk) disable iff (rst)
    ((a_cls == CLS_JUMP && a_mark) || (b_cls == CLS_JUMP && b_mark)) |-> dep_comb);
  p_jsrc_store_r10: assert property (@(posedge clk) disable iff (rst)
    (a_cls == CLS_JUMP && !a_mark && b_cls == CLS_LDST && b_mark) |-> dep_comb);
  p_no_match_r11: assert property (@(posedge clk) disable iff (rst)
    (a_cls != CLS_JUMP && b_cls != CLS_JUMP && a_mem != b_mem &&
     a_reg0 != b_reg0 && a_reg0 != b_reg1 && a_reg0 != b_reg2 &&
     a_reg1 != b_reg0 && a_reg2 != b_reg0) |-> !dep_comb);
  p_alu_first_r3: assert property (@(posedge clk) disable iff (rst)
    (a_cls[1] && b_cls != CLS_JUMP && a_reg0 == b_reg0) |-> dep_comb);
endmodule

// File: tb/sim_dep_check_top.sv
module sim_dep_check_top;
  localparam int RW = 5;
  localparam int MW = 8;

  typedef struct packed {
    logic [1:0]    cls;
    logic          mk;
    logic [RW-1:0] r0, r1, r2;
    logic [MW-1:0] m;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  ins_t ia, ib;
  logic snm = 1'b0, mth = 1'b0;
  logic dep0, ov0, dep1, ov1;
  int   n_chk = 0, n_err = 0;
  logic last_exp = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  dep_check_top #(.RW(RW), .MW(MW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_cls(ia.cls), .a_mark(ia.mk), .a_reg0(ia.r0), .a_reg1(ia.r1), .a_reg2(ia.r2), .a_mem(ia.m),
    .b_cls(ib.cls), .b_mark(ib.mk), .b_reg0(ib.r0), .b_reg1(ib.r1), .b_reg2(ib.r2), .b_mem(ib.m),
    .slot_mismatch(snm), .min_target_hit(mth), .out_valid(ov0), .dep(dep0));

  dep_check_top #(.RW(RW), .MW(MW), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_cls(ia.cls), .a_mark(ia.mk), .a_reg0(ia.r0), .a_reg1(ia.r1), .a_reg2(ia.r2), .a_mem(ia.m),
    .b_cls(ib.cls), .b_mark(ib.mk), .b_reg0(ib.r0), .b_reg1(ib.r1), .b_reg2(ib.r2), .b_mem(ib.m),
    .slot_mismatch(snm), .min_target_hit(mth), .out_valid(ov1), .dep(dep1));

  function automatic ins_t mk(input logic [1:0] c, input logic k,
                              input int r0, input int r1, input int r2, input int m);
    ins_t x;
    x.cls = c; x.mk = k;
    x.r0 = RW'(r0); x.r1 = RW'(r1); x.r2 = RW'(r2); x.m = MW'(m);
    return x;
  endfunction

  // Expected result written from the requirement text
  function automatic logic ref_dep(input ins_t a, input ins_t b, input logic s, input logic h);
    logic ajs = a.cls == 2'b00 && !a.mk, ajd = a.cls == 2'b00 && a.mk;
    logic ald = a.cls == 2'b01 && !a.mk, ast = a.cls == 2'b01 && a.mk;
    logic aal = a.cls[1], abn = a.cls == 2'b11;
    logic bjs = b.cls == 2'b00 && !b.mk, bjd = b.cls == 2'b00 && b.mk;
    logic bld = b.cls == 2'b01 && !b.mk, bst = b.cls == 2'b01 && b.mk;
    logic bal = b.cls[1], bbn = b.cls == 2'b11;
    logic bnj = b.cls != 2'b00;
    logic d = 1'b0;
    if (ald && bnj && a.r0 == b.r0) d = 1'b1;
    if (ast && (bld || bal) && a.r0 == b.r0) d = 1'b1;
    if (aal && bnj && a.r0 == b.r0) d = 1'b1;
    if (bal && (ald || aal) && a.r0 == b.r1) d = 1'b1;
    if (bbn && (ald || aal) && a.r0 == b.r2) d = 1'b1;
    if (ast && a.m == b.m) d = 1'b1;
    if (ald && bst && a.m == b.m) d = 1'b1;
    if (ast && bjs && s) d = 1'b1;
    if (aal && bnj && a.r1 == b.r0) d = 1'b1;
    if (abn && bnj && a.r2 == b.r0) d = 1'b1;
    if (ajd || bjd) d = 1'b1;
    if (ajs && h) d = 1'b1;
    if (ajs && (bst || bjs)) d = 1'b1;
    return d;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input ins_t a, input ins_t b,
                       input logic s, input logic h, input logic want_known, input logic want);
    logic e;
    @(negedge clk);
    ia = a; ib = b; snm = s; mth = h; in_valid = 1'b1;
    e = ref_dep(a, b, s, h);
    if (want_known) chk({tag, " model"}, e, want);
    #1;
    chk({tag, " R13 comb dep"}, dep1, e);
    chk({tag, " R13 comb valid"}, ov1, 1'b1);
    @(posedge clk); #1;
    chk({tag, " R12 reg dep"}, dep0, e);
    chk({tag, " R12 reg valid"}, ov0, 1'b1);
    last_exp = e;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5eed);
    ia = '0; ib = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset valid", ov0, 1'b0);
    chk("R12 reset dep", dep0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // Directed corners: (class, mark, reg0, reg1, reg2, mem)
    apply("R11 no term", mk(2'b01,0,1,9,9,10), mk(2'b01,0,2,9,9,11), 0, 0, 1, 0);
    apply("R1 R2 load vs bin", mk(2'b01,0,3,8,8,10), mk(2'b11,0,3,4,5,11), 0, 0, 1, 1);
    apply("R2 store vs load", mk(2'b01,1,6,8,8,10), mk(2'b01,0,6,4,5,11), 0, 0, 1, 1);
    apply("R3 unary vs store", mk(2'b10,0,5,8,8,10), mk(2'b01,1,5,4,6,11), 0, 0, 1, 1);
    apply("R4 load vs bin reg1", mk(2'b01,0,7,8,8,10), mk(2'b11,0,1,7,2,11), 0, 0, 1, 1);
    apply("R4 unary reg2 ignored", mk(2'b01,0,7,8,8,10), mk(2'b10,0,1,2,7,11), 0, 0, 1, 0);
    apply("R5 store mem vs jump src", mk(2'b01,1,1,8,8,20), mk(2'b00,0,2,4,5,20), 0, 0, 1, 1);
    apply("R5 load vs store mem", mk(2'b01,0,1,8,8,21), mk(2'b01,1,2,4,5,21), 0, 0, 1, 1);
    apply("R6 store jsrc flag", mk(2'b01,1,1,8,8,20), mk(2'b00,0,2,4,5,22), 1, 0, 1, 1);
    apply("R6 store jsrc no flag", mk(2'b01,1,1,8,8,20), mk(2'b00,0,2,4,5,22), 0, 0, 1, 0);
    apply("R7 bin reg2 vs b reg0", mk(2'b11,0,1,2,9,20), mk(2'b10,0,9,4,5,22), 0, 0, 1, 1);
    apply("R7 unary reg2 ignored", mk(2'b10,0,1,2,9,20), mk(2'b10,0,9,4,5,22), 0, 0, 1, 0);
    apply("R8 A jump dest", mk(2'b00,1,1,2,3,20), mk(2'b10,0,9,4,5,22), 0, 0, 1, 1);
    apply("R8 B jump dest", mk(2'b10,0,1,2,3,20), mk(2'b00,1,9,4,5,22), 0, 0, 1, 1);
    apply("R9 jsrc min flag", mk(2'b00,0,1,2,3,20), mk(2'b10,0,9,4,5,22), 0, 1, 1, 1);
    apply("R9 jsrc no flag", mk(2'b00,0,1,2,3,20), mk(2'b10,0,1,1,1,20), 0, 0, 1, 0);
    apply("R10 jsrc vs store", mk(2'b00,0,1,2,3,20), mk(2'b01,1,9,4,5,22), 0, 0, 1, 1);
    apply("R10 jsrc vs jsrc", mk(2'b00,0,1,2,3,20), mk(2'b00,0,9,4,5,22), 0, 0, 1, 1);
    apply("R10 jsrc vs load", mk(2'b00,0,1,2,3,20), mk(2'b01,0,1,2,3,20), 0, 0, 1, 0);

    // R12 hold: idle cycle with inputs that would flip the result
    @(negedge clk);
    in_valid = 1'b0;
    ia = mk(2'b00,1,0,0,0,0);
    #1 chk("R13 comb idle valid", ov1, 1'b0);
    @(posedge clk); #1;
    chk("R12 idle valid", ov0, 1'b0);
    chk("R12 idle hold dep", dep0, last_exp);

    // Sweep of all class/marker pairs with random operands (R1..R11)
    for (int ac = 0; ac < 4; ac++)
      for (int af = 0; af < 2; af++)
        for (int bc = 0; bc < 4; bc++)
          for (int bf = 0; bf < 2; bf++)
            for (int k = 0; k < 16; k++) begin
              ins_t ra, rb;
              ra = mk(2'(ac), 1'(af), int'($urandom_range(3)), int'($urandom_range(3)),
                      int'($urandom_range(3)), int'($urandom_range(3)));
              rb = mk(2'(bc), 1'(bf), int'($urandom_range(3)), int'($urandom_range(3)),
                      int'($urandom_range(3)), int'($urandom_range(3)));
              apply("R11 sweep", ra, rb, 1'($urandom_range(1)), 1'($urandom_range(1)), 0, 0);
            end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule